// File: doc/BRIEF.md
# Masked Vector Execution Unit

This unit runs one element-wise vector instruction at a time over two source vectors. The vectors live outside the block. The unit drives an element index, reads both operands for that index in the same cycle, and returns results through a registered write port that has its own write enable. An internal per-element mask decides which elements are acted on. The mask is loaded by a compare instruction that visits every element, and an invert instruction complements it. A two-way select then takes four instructions: compare to form the mask, a masked copy of the first source, an invert, and a masked copy of the second source.

Two execution styles are offered. In the sequential style every element inside the vector length passes through the operator, and the mask only gates the write enable. In the skipping style a priority encoder picks the lowest pending mask bit in each cycle, so the run time follows the number of set bits and not the vector length. A one-cycle done pulse closes every instruction.

Top module: `mvx_unit`

## Requirements
- R1: After reset, busy_o, done_o and wr_en_o are 0 and mask_o is all zero.
- R2: Command code 1 (compare) clears the mask and then visits the elements 0 to vlen-1 in order, one per cycle, setting mask bit i from the compare selected by tst_i: 0 means A[i]==0, 1 means A[i]!=0, 2 means signed A[i]>=B[i], and 3 gives 0. Mask bits at or above vlen are 0 when it ends, and busy_o is high for max(vlen,1) cycles.
- R3: Command code 2 (invert) sets the mask to its complement inside the first vlen bits and clears every bit above them. busy_o stays low and done_o pulses in the cycle after the start.
- R4: Command code 0 (execute) with dense_i=0 reads the elements 0 to vlen-1 in order, one per cycle, with busy_o high for max(vlen,1) cycles. It writes element i only when mask bit i is set.
- R5: Execute with dense_i=1 issues only the elements whose mask bit is set and that lie below vlen, one per cycle in ascending index order with no idle cycle between them. busy_o is high for max(popcount,1) cycles.
- R6: op_i selects the element result: 0 gives A+B, 1 gives A-B, 2 gives the low W bits of A*B, and 3 passes A. The arithmetic wraps modulo 2^W.
- R7: A write appears on the write port one cycle after its element is read, with wr_idx_o equal to that element. done_o is high for one cycle, in the cycle after the last busy cycle, together with the final write.
- R8: A vlen_i larger than N is treated as N.
- R9: An all-zero mask produces no write in either style. The skipping style then finishes after a single busy cycle.
- R10: start_i is ignored while busy_o is high.
- R11: Command code 3 does nothing except pulse done_o in the cycle after the start, and the mask keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Starts an instruction while the unit is idle |
| cmd_i | input | 2 | Command: 0 execute, 1 compare, 2 invert, 3 no-op |
| op_i | input | 2 | Element operation used by execute |
| tst_i | input | 2 | Compare selector used by compare |
| dense_i | input | 1 | 1 selects the skipping style for execute |
| vlen_i | input | $clog2(N+1) | Active vector length |
| rd_idx_o | output | $clog2(N) | Element index being read |
| a_i | input | W | First source element at rd_idx_o |
| b_i | input | W | Second source element at rd_idx_o |
| wr_en_o | output | 1 | Result write enable |
| wr_idx_o | output | $clog2(N) | Result element index |
| wr_data_o | output | W | Result element value |
| busy_o | output | 1 | An instruction is stepping through elements |
| done_o | output | 1 | One-cycle completion pulse |
| mask_o | output | N | Current element mask |

## Verification
Each table row first loads a mask pattern through a not-equal-to-zero compare, then runs execute with a chosen operation, style and length. The patterns cover full, sparse, alternating, empty, edge-only and length-truncated masks. Comparing the busy count of the two styles on the same pattern shows whether masked-off elements are really skipped. The result cells left at a sentinel show whether a masked write was suppressed. A signed select with negative values checks the greater-or-equal compare together with invert, and a full-length, zero, over-range and short vector length each check that the length bound is applied in both styles.

// File: rtl/mvx_pkg.sv
package mvx_pkg;
  typedef enum logic [1:0] {
    CMD_EXEC = 2'd0,
    CMD_TEST = 2'd1,
    CMD_INV  = 2'd2,
    CMD_NOP  = 2'd3
  } mvx_cmd_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_MUL  = 2'd2,
    OP_PASS = 2'd3
  } mvx_op_e;

  typedef enum logic [1:0] {
    TST_EQZ = 2'd0,
    TST_NEZ = 2'd1,
    TST_GE  = 2'd2,
    TST_OFF = 2'd3
  } mvx_tst_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mvx_st_e;
endpackage

// File: rtl/mvx_alu.sv
module mvx_alu
  import mvx_pkg::*;
#(
  parameter int W = 16
) (
  input  mvx_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  logic [2*W-1:0] prod;

  assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = prod[W-1:0];
      default: y = a;
    endcase
  end
endmodule

// File: rtl/mvx_cmp.sv
module mvx_cmp
  import mvx_pkg::*;
#(
  parameter int W = 16
) (
  input  mvx_tst_e       tst,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           hit
);
  always_comb begin
    unique case (tst)
      TST_EQZ: hit = (a == '0);
      TST_NEZ: hit = (a != '0);
      TST_GE:  hit = ($signed(a) >= $signed(b));
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/mvx_prienc.sv
module mvx_prienc #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/mvx_lenmask.sv
module mvx_lenmask #(
  parameter int N  = 16,
  parameter int LW = $clog2(N + 1)
) (
  input  logic [LW-1:0] len,
  output logic [N-1:0]  m
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign m[g] = (LW'(g) < len);
  end
endmodule

// File: rtl/mvx_unit.sv
module mvx_unit
  import mvx_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [1:0]                 cmd_i,
  input  logic [1:0]                 op_i,
  input  logic [1:0]                 tst_i,
  input  logic                       dense_i,
  input  logic [$clog2(N+1)-1:0]     vlen_i,
  output logic [$clog2(N)-1:0]       rd_idx_o,
  input  logic [W-1:0]               a_i,
  input  logic [W-1:0]               b_i,
  output logic                       wr_en_o,
  output logic [$clog2(N)-1:0]       wr_idx_o,
  output logic [W-1:0]               wr_data_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [N-1:0]               mask_o
);
  localparam int IW = $clog2(N);
  localparam int LW = $clog2(N + 1);
  localparam logic [LW-1:0] NMAX = LW'(N);

  // reset release synchronizer
  logic [1:0] rs_q;
  logic       rst_ln;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ln = rs_q[1];

  // state
  mvx_st_e         st_q, st_n;
  mvx_cmd_e        cmd_q, cmd_n;
  mvx_op_e         op_q, op_n;
  mvx_tst_e        tst_q, tst_n;
  logic            dense_q, dense_n;
  logic [LW-1:0]   vlen_q, vlen_n;
  logic [IW-1:0]   idx_q, idx_n;
  logic [N-1:0]    rem_q, rem_n;
  logic [N-1:0]    mask_q, mask_n;
  logic            wr_en_q, wr_en_n;
  logic [IW-1:0]   wr_idx_q, wr_idx_n;
  logic [W-1:0]    wr_data_q, wr_data_n;
  logic            done_q, done_n;

  // datapath helpers
  logic [LW-1:0]   vlen_cl;
  logic [N-1:0]    lm_start;
  logic [IW-1:0]   pe_idx;
  logic            pe_any;
  logic [N-1:0]    rem_clr;
  logic            skip_mode;
  logic [IW-1:0]   cur_idx;
  logic            in_len;
  logic            last_seq;
  logic            last_el;
  logic [W-1:0]    alu_y;
  logic            cmp_hit;
  logic            accept;
  logic            cfg_en;

  assign vlen_cl = (vlen_i > NMAX) ? NMAX : vlen_i;

  mvx_lenmask #(.N(N), .LW(LW)) u_lenmask (
    .len (vlen_cl),
    .m   (lm_start)
  );

  mvx_prienc #(.N(N), .IW(IW)) u_prienc (
    .req (rem_q),
    .idx (pe_idx),
    .any (pe_any)
  );

  assign skip_mode = dense_q && (cmd_q == CMD_EXEC);
  assign cur_idx   = skip_mode ? pe_idx : idx_q;
  assign rem_clr   = rem_q & ~(N'(1) << pe_idx);
  assign in_len    = (LW'(idx_q) < vlen_q);
  assign last_seq  = ((LW'(idx_q) + LW'(1)) >= vlen_q);
  assign last_el   = skip_mode ? (rem_clr == '0) : last_seq;

  mvx_alu #(.W(W)) u_alu (
    .op (op_q),
    .a  (a_i),
    .b  (b_i),
    .y  (alu_y)
  );

  mvx_cmp #(.W(W)) u_cmp (
    .tst (tst_q),
    .a   (a_i),
    .b   (b_i),
    .hit (cmp_hit)
  );

  assign accept = (st_q == ST_IDLE) && start_i;
  assign cfg_en = accept;

  // next-state logic
  always_comb begin
    st_n      = st_q;
    cmd_n     = cmd_q;
    op_n      = op_q;
    tst_n     = tst_q;
    dense_n   = dense_q;
    vlen_n    = vlen_q;
    idx_n     = idx_q;
    rem_n     = rem_q;
    mask_n    = mask_q;
    wr_en_n   = 1'b0;
    wr_idx_n  = wr_idx_q;
    wr_data_n = wr_data_q;
    done_n    = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          cmd_n   = mvx_cmd_e'(cmd_i);
          op_n    = mvx_op_e'(op_i);
          tst_n   = mvx_tst_e'(tst_i);
          dense_n = dense_i;
          vlen_n  = vlen_cl;
          idx_n   = '0;
          unique case (mvx_cmd_e'(cmd_i))
            CMD_EXEC: begin
              rem_n = mask_q & lm_start;
              st_n  = ST_RUN;
            end
            CMD_TEST: begin
              mask_n = '0;
              st_n   = ST_RUN;
            end
            CMD_INV: begin
              mask_n = ~mask_q & lm_start;
              done_n = 1'b1;
            end
            default: begin
              done_n = 1'b1;
            end
          endcase
        end
      end
      default: begin
        if (cmd_q == CMD_TEST) begin
          if (in_len) mask_n[idx_q] = cmp_hit;
        end else begin
          wr_en_n   = skip_mode ? pe_any : (in_len && mask_q[idx_q]);
          wr_idx_n  = cur_idx;
          wr_data_n = alu_y;
          if (skip_mode) rem_n = rem_clr;
        end
        idx_n = idx_q + IW'(1);
        if (last_el) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end
      end
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
      mask_q  <= '0;
      wr_en_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      idx_q   <= idx_n;
      rem_q   <= rem_n;
      mask_q  <= mask_n;
      wr_en_q <= wr_en_n;
      done_q  <= done_n;
    end
  end

  // instruction configuration, loaded on accept
  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      cmd_q   <= CMD_NOP;
      op_q    <= OP_ADD;
      tst_q   <= TST_EQZ;
      dense_q <= 1'b0;
      vlen_q  <= '0;
    end else if (cfg_en) begin
      cmd_q   <= cmd_n;
      op_q    <= op_n;
      tst_q   <= tst_n;
      dense_q <= dense_n;
      vlen_q  <= vlen_n;
    end
  end

  // write payload, loaded on an enabled write
  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else if (wr_en_n) begin
      wr_idx_q  <= wr_idx_n;
      wr_data_q <= wr_data_n;
    end
  end

  assign rd_idx_o  = (st_q == ST_RUN) ? cur_idx : '0;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign busy_o    = (st_q == ST_RUN);
  assign done_o    = done_q;
  assign mask_o    = mask_q;
endmodule

// File: rtl/mvx_unit_chk.sv
module mvx_unit_chk #(
  parameter int N = 16,
  parameter int W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   wr_en_o,
  input logic [$clog2(N)-1:0]   wr_idx_o,
  input logic [N-1:0]           mask_o,
  input logic [1:0]             cmd_q,
  input logic [$clog2(N+1)-1:0] vlen_q
);
  localparam int LW = $clog2(N + 1);

  logic [N-1:0] in_range;
  always_comb begin
    for (int i = 0; i < N; i++) in_range[i] = (LW'(i) < vlen_q);
  end

  // R4: a write only targets an element whose mask bit is set
  a_r4_write_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> mask_o[wr_idx_o]);

  // R5: writes within one instruction go to strictly rising indices
  a_r5_ascending_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(wr_en_o) && !$past(done_o)) |-> (wr_idx_o > $past(wr_idx_o)));

  // R7: the done pulse comes after the last busy cycle
  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R10: busy only begins from an accepted start
  a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R2 / R3: after compare or invert no mask bit lies beyond the length
  a_r2_mask_within_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (cmd_q == 2'd1 || cmd_q == 2'd2)) |-> ((mask_o & ~in_range) == '0));

  // R8: latched length never exceeds the element count
  a_r8_len_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    vlen_q <= LW'(N));

  // R2: only execute writes results
  a_r2_write_only_exec: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (cmd_q == 2'd0));
endmodule

bind mvx_unit mvx_unit_chk #(.N(N), .W(W)) u_mvx_unit_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .wr_en_o  (wr_en_o),
  .wr_idx_o (wr_idx_o),
  .mask_o   (mask_o),
  .cmd_q    (cmd_q),
  .vlen_q   (vlen_q)
);

// File: tb/test_mvx_unit.sv
module test_mvx_unit;
  localparam int N  = 16;
  localparam int W  = 16;
  localparam int IW = 4;
  localparam int LW = 5;
  localparam logic [W-1:0] SENT = 16'hBEEF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    cmd_i = 2'd0;
  logic [1:0]    op_i = 2'd0;
  logic [1:0]    tst_i = 2'd0;
  logic          dense_i = 1'b0;
  logic [LW-1:0] vlen_i = '0;
  logic [IW-1:0] rd_idx_o;
  logic [W-1:0]  a_i, b_i;
  logic          wr_en_o;
  logic [IW-1:0] wr_idx_o;
  logic [W-1:0]  wr_data_o;
  logic          busy_o, done_o;
  logic [N-1:0]  mask_o;

  logic [W-1:0]  mem_a [N];
  logic [W-1:0]  mem_b [N];
  logic [W-1:0]  res   [N];
  logic          swap = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int order_bad;

  always #2 clk = ~clk;

  assign a_i = swap ? mem_b[rd_idx_o] : mem_a[rd_idx_o];
  assign b_i = swap ? mem_a[rd_idx_o] : mem_b[rd_idx_o];

  mvx_unit #(.N(N), .W(W)) i_mvx_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .op_i(op_i),
    .tst_i(tst_i), .dense_i(dense_i), .vlen_i(vlen_i), .rd_idx_o(rd_idx_o),
    .a_i(a_i), .b_i(b_i), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
    .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o), .mask_o(mask_o)
  );

  typedef struct packed {
    logic [15:0]   pat;
    logic [15:0]   seed;
    logic [1:0]    op;
    logic          dense;
    logic [LW-1:0] vlen;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{16'hFFFF, 16'd1234,  2'd0, 1'b0, 5'd16},
    '{16'hA5A5, 16'd7,     2'd1, 1'b1, 5'd16},
    '{16'h00F0, 16'd300,   2'd2, 1'b0, 5'd10},
    '{16'h8001, 16'd9,     2'd3, 1'b1, 5'd16},
    '{16'h0000, 16'd5,     2'd0, 1'b1, 5'd16},
    '{16'hFFFF, 16'd40000, 2'd2, 1'b1, 5'd20},
    '{16'h3C3C, 16'd65535, 2'd0, 1'b0, 5'd0},
    '{16'h0FF0, 16'd17,    2'd1, 1'b1, 5'd7}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] lenmask(input int v);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (i < v);
    return m;
  endfunction

  function automatic int popc(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [W-1:0] ref_op(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] p;
    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return p[W-1:0];
      default: return a;
    endcase
  endfunction

  task automatic clear_res();
    for (int i = 0; i < N; i++) res[i] = SENT;
  endtask

  task automatic run(input logic [1:0] cmd, input logic [1:0] op, input logic [1:0] tst,
                     input logic dn, input logic [LW-1:0] vl, input int poke,
                     output int nbusy, output int ncyc);
    int prev;
    bit fin;
    @(negedge clk);
    cmd_i = cmd; op_i = op; tst_i = tst; dense_i = dn; vlen_i = vl; start_i = 1'b1;
    nbusy = 0; ncyc = 0; prev = -1; order_bad = 0; fin = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      ncyc++;
      if (busy_o) nbusy++;
      if (wr_en_o) begin
        if (prev >= 0 && int'(wr_idx_o) <= prev) order_bad++;
        prev = int'(wr_idx_o);
        res[wr_idx_o] = wr_data_o;
      end
      if (poke != 0 && ncyc == poke) begin
        cmd_i = 2'd2; start_i = 1'b1;
      end
      if (done_o) begin
        fin = 1'b1;
        break;
      end
    end
    start_i = 1'b0;
    chk(fin, "R7 done seen", 32'(fin), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int nb, nc, vcl, expb;
    logic [N-1:0] pm, em;
    logic [W-1:0] ev;
    logic [W-1:0] sa [8];
    logic [W-1:0] sb [8];

    for (int i = 0; i < N; i++) begin mem_a[i] = '0; mem_b[i] = '0; end
    clear_res();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o == 1'b0, "R1 busy", 32'(busy_o), 0);
    chk(done_o == 1'b0, "R1 done", 32'(done_o), 0);
    chk(wr_en_o == 1'b0, "R1 wr_en", 32'(wr_en_o), 0);
    chk(mask_o == '0, "R1 mask", 32'(mask_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mask_o == '0 && !busy_o, "R1 after release", 32'(mask_o), 0);

    // table walk: load mask by compare, then execute
    for (int t = 0; t < NV; t++) begin
      pm = TBL[t].pat;
      vcl = (int'(TBL[t].vlen) > N) ? N : int'(TBL[t].vlen);
      for (int i = 0; i < N; i++) begin
        mem_a[i] = pm[i] ? ((TBL[t].seed ^ W'(i * 37)) | 16'h0001) : '0;
        mem_b[i] = TBL[t].seed * 16'd3 + W'(i * 11);
      end
      run(2'd1, 2'd0, 2'd1, 1'b0, TBL[t].vlen, 0, nb, nc);
      em = pm & lenmask(vcl);
      chk(mask_o == em, "R2 table mask", 32'(mask_o), 32'(em));
      expb = (vcl > 0) ? vcl : 1;
      chk(nb == expb, "R2 R8 compare busy", nb, expb);
      clear_res();
      run(2'd0, TBL[t].op, 2'd0, TBL[t].dense, TBL[t].vlen, 0, nb, nc);
      if (TBL[t].dense) expb = (popc(em) > 0) ? popc(em) : 1;
      else              expb = (vcl > 0) ? vcl : 1;
      chk(nb == expb, TBL[t].dense ? "R5 R9 skip busy" : "R4 R8 seq busy", nb, expb);
      chk(nc == expb + 1, "R7 done latency", nc, expb + 1);
      chk(order_bad == 0, "R5 ascending order", order_bad, 0);
      for (int i = 0; i < N; i++) begin
        ev = em[i] ? ref_op(TBL[t].op, mem_a[i], mem_b[i]) : SENT;
        chk(res[i] == ev, "R6 R9 result element", 32'(res[i]), 32'(ev));
      end
    end

    // R3: invert inside length, upper bits cleared
    for (int i = 0; i < N; i++) mem_a[i] = (16'h0123 >> i) & 16'h1;
    run(2'd1, 2'd0, 2'd1, 1'b0, 5'd12, 0, nb, nc);
    chk(mask_o == 16'h0123, "R2 nez mask", 32'(mask_o), 32'h0123);
    run(2'd2, 2'd0, 2'd0, 1'b0, 5'd12, 0, nb, nc);
    chk(mask_o == 16'h0EDC, "R3 invert mask", 32'(mask_o), 32'h0EDC);
    chk(nb == 0 && nc == 1, "R3 invert timing", nc, 1);

    // R11: no-op keeps mask
    run(2'd3, 2'd0, 2'd0, 1'b0, 5'd16, 0, nb, nc);
    chk(mask_o == 16'h0EDC && nc == 1 && nb == 0, "R11 nop", 32'(mask_o), 32'h0EDC);

    // R2: equal-to-zero and the disabled compare code
    run(2'd1, 2'd0, 2'd0, 1'b0, 5'd16, 0, nb, nc);
    chk(mask_o == 16'hFEDC, "R2 eqz mask", 32'(mask_o), 32'hFEDC);
    run(2'd1, 2'd0, 2'd3, 1'b0, 5'd16, 0, nb, nc);
    chk(mask_o == 16'h0000, "R2 code3 mask", 32'(mask_o), 0);

    // R2 R3 R6: signed select of the larger element in four steps
    sa = '{16'd1, 16'd2, 16'd3, 16'd4, -16'sd5, -16'sd3, 16'd6, -16'sd7};
    sb = '{16'd2, 16'd2, 16'd2, 16'd10, -16'sd4, 16'd0, 16'd5, -16'sd8};
    for (int i = 0; i < N; i++) begin
      mem_a[i] = (i < 8) ? sa[i] : 16'd99;
      mem_b[i] = (i < 8) ? sb[i] : 16'd77;
    end
    em = '0;
    for (int i = 0; i < 8; i++) em[i] = ($signed(sa[i]) >= $signed(sb[i]));
    run(2'd1, 2'd0, 2'd2, 1'b0, 5'd8, 0, nb, nc);
    chk(mask_o == em, "R2 signed ge mask", 32'(mask_o), 32'(em));
    clear_res();
    run(2'd0, 2'd3, 2'd0, 1'b0, 5'd8, 0, nb, nc);
    run(2'd2, 2'd0, 2'd0, 1'b0, 5'd8, 0, nb, nc);
    chk(mask_o == (~em & 16'h00FF), "R3 select invert", 32'(mask_o), 32'(~em & 16'h00FF));
    swap = 1'b1;
    run(2'd0, 2'd3, 2'd0, 1'b1, 5'd8, 0, nb, nc);
    swap = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (i < 8) ev = ($signed(sa[i]) >= $signed(sb[i])) ? sa[i] : sb[i];
      else       ev = SENT;
      chk(res[i] == ev, "R6 select result", 32'(res[i]), 32'(ev));
    end

    // R10: start while busy is ignored
    for (int i = 0; i < N; i++) begin mem_a[i] = W'(i + 1); mem_b[i] = 16'd1; end
    run(2'd1, 2'd0, 2'd1, 1'b0, 5'd16, 0, nb, nc);
    clear_res();
    run(2'd0, 2'd0, 2'd0, 1'b0, 5'd16, 5, nb, nc);
    chk(nb == 16, "R10 busy unchanged", nb, 16);
    chk(mask_o == 16'hFFFF, "R10 mask unchanged", 32'(mask_o), 32'hFFFF);
    chk(res[15] == 16'd17, "R10 last element", 32'(res[15]), 17);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule